// File: doc/BRIEF.md
# Critical-Word-First Line Refill

This block refills one cache line of `WORDS` words from memory. When the CPU reads a word of a line the block does not hold, the block starts a fill. It asks memory for the missed word first. It then asks for the other words in wrap-around order. Each word that comes back is written into a line buffer, and that word's valid bit is set. The missed word is passed to the CPU in the same cycle it arrives, so the CPU can go on working while the rest of the line loads.

During a fill, reads to the same line are handled word by word. A word that has already arrived is returned from the buffer at once. A word that has not arrived holds the CPU until it comes back from memory. A read to a different line waits until the current fill has finished, and then starts a new fill. The block does not manage tags for any line other than the one it holds.

Top module: `cwf_refill`

## Requirements
- R1: A read to a line that is not held, made while no fill is running, starts a fill. In the next cycle the first memory request carries that line and the missed word offset.
- R2: The fill issues exactly `WORDS` requests, one per grant. After the critical offset c they follow c+1, c+2, … modulo `WORDS`, wrapping to zero.
- R3: When a pending read is waiting on offset k and a memory response with offset k arrives, `cpu_rvalid_o` is high in that same cycle and `cpu_rdata_o` equals `mem_rdata_i`.
- R4: Each response is stored at its offset and that word is marked valid. A later read of that word in the held line is answered in the cycle of the request, with the stored data.
- R5: A read to the held line for a word that has not yet arrived keeps `cpu_rvalid_o` low until that word's response.
- R6: `line_full_o` is high only when a line is held and all `WORDS` valid bits are set. It is low while a fill is still waiting on words.
- R7: A read to another line during a fill gets no response and starts no new requests until the current fill completes. It then starts its own fill as in R1.
- R8: After reset no line is held, and `mem_req_o`, `cpu_rvalid_o` and `line_full_o` are low.
- R9: While `mem_req_o` is high and `mem_gnt_i` is low, the request stays asserted with the same line and offset in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU read request, held until answered |
| cpu_line_i | input | LINE_W | Line address of the read |
| cpu_off_i | input | OFF_W | Word offset of the read |
| cpu_rvalid_o | output | 1 | Read answered this cycle |
| cpu_rdata_o | output | DATA_W | Read data |
| mem_req_o | output | 1 | Memory word request |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_line_o | output | LINE_W | Line address of the request |
| mem_off_o | output | OFF_W | Word offset of the request |
| mem_rvalid_i | input | 1 | Memory response valid, one word |
| mem_roff_i | input | OFF_W | Word offset of the response |
| mem_rdata_i | input | DATA_W | Response data |
| line_full_o | output | 1 | Held line completely valid |

## Verification
The bench tries fills whose critical offset is zero, in the middle of the line, and the last word. This shows the wrap ordering apart from a plain ascending count. Reads that follow a miss are aimed at words that have already arrived, at the word arriving in that very cycle, and at words still outstanding. These cases separate a buffer hit, early forwarding and a stall. A read to a second line is issued during an active fill, and a grant that drops every third cycle shows whether a request is held steady while it waits. A reference model in the bench is compared against every output on every clock.

// File: rtl/cwf_refill_pkg.sv
package cwf_refill_pkg;
  localparam int unsigned DEF_WORDS  = 4;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_LINE_W = 8;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cwf_req_seq.sv
module cwf_req_seq #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned LINE_W = 8,
  localparam int unsigned OFF_W = cwf_refill_pkg::idx_w(WORDS),
  localparam int unsigned CNT_W = $clog2(WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  crit_i,
  input  logic              mem_gnt_i,
  output logic              mem_req_o,
  output logic [LINE_W-1:0] mem_line_o,
  output logic [OFF_W-1:0]  mem_off_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OFF_W-1:0]  crit_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      crit_q   <= '0;
      line_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      crit_q   <= crit_i;
      line_q   <= line_i;
    end else if (active_q && mem_gnt_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) active_q <= 1'b0;
    end
  end

  // offset arithmetic wraps modulo WORDS (power of two)
  assign mem_req_o  = active_q;
  assign mem_line_o = line_q;
  assign mem_off_o  = crit_q + cnt_q[OFF_W-1:0];
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned OFF_W = cwf_refill_pkg::idx_w(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [WORDS-1:0]  valid_o
);
  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_i && (wr_off_i == OFF_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[w] <= 1'b0;
        word_q[w]  <= '0;
      end else if (clr_i) begin
        valid_o[w] <= 1'b0;
      end else if (hit) begin
        valid_o[w] <= 1'b1;
        word_q[w]  <= wr_data_i;
      end
    end
  end

  assign rd_data_o  = word_q[rd_off_i];
  assign rd_valid_o = valid_o[rd_off_i];
endmodule

// File: rtl/cwf_refill.sv
module cwf_refill #(
  parameter int unsigned WORDS  = cwf_refill_pkg::DEF_WORDS,
  parameter int unsigned DATA_W = cwf_refill_pkg::DEF_DATA_W,
  parameter int unsigned LINE_W = cwf_refill_pkg::DEF_LINE_W,
  localparam int unsigned OFF_W = cwf_refill_pkg::idx_w(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [LINE_W-1:0] cpu_line_i,
  input  logic [OFF_W-1:0]  cpu_off_i,
  output logic              cpu_rvalid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [LINE_W-1:0] mem_line_o,
  output logic [OFF_W-1:0]  mem_off_o,
  input  logic              mem_rvalid_i,
  input  logic [OFF_W-1:0]  mem_roff_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              line_full_o
);
  logic              busy_q, held_q;
  logic [LINE_W-1:0] line_q;
  logic              same_line, start, fill_wr, fwd, all_next;
  logic [WORDS-1:0]  valid, set_mask;
  logic [DATA_W-1:0] buf_data;
  logic              buf_ok;

  assign same_line = held_q && (cpu_line_i == line_q);
  assign start     = cpu_req_i && !same_line && !busy_q;
  assign fill_wr   = mem_rvalid_i && busy_q;
  assign set_mask  = fill_wr ? (WORDS'(1) << mem_roff_i) : '0;
  assign all_next  = &(valid | set_mask);
  assign fwd       = fill_wr && (mem_roff_i == cpu_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      held_q <= 1'b0;
      line_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      held_q <= 1'b1;
      line_q <= cpu_line_i;
    end else if (busy_q && all_next) begin
      busy_q <= 1'b0;
    end
  end

  cwf_req_seq #(.WORDS(WORDS), .LINE_W(LINE_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i   (start),
    .line_i    (cpu_line_i),
    .crit_i    (cpu_off_i),
    .mem_gnt_i,
    .mem_req_o,
    .mem_line_o,
    .mem_off_o
  );

  cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .clr_i     (start),
    .wr_i      (fill_wr),
    .wr_off_i  (mem_roff_i),
    .wr_data_i (mem_rdata_i),
    .rd_off_i  (cpu_off_i),
    .rd_data_o (buf_data),
    .rd_valid_o(buf_ok),
    .valid_o   (valid)
  );

  // stored word wins; otherwise the arriving word is forwarded
  assign cpu_rvalid_o = cpu_req_i && same_line && (buf_ok || fwd);
  assign cpu_rdata_o  = buf_ok ? buf_data : mem_rdata_i;
  assign line_full_o  = held_q && (&valid);
endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINE_W = 8,
  localparam int unsigned OFF_W = cwf_refill_pkg::idx_w(WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_rvalid_o,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic [LINE_W-1:0] mem_line_o,
  input logic [OFF_W-1:0]  mem_off_o,
  input logic              mem_rvalid_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              line_full_o,
  input logic              buf_ok
);
  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_off_o) && $stable(mem_line_o)));

  a_r2_wrap_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> (!mem_req_o || mem_off_o == $past(mem_off_o) + 1'b1));

  a_r6_full_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_full_o |-> !mem_req_o);

  a_r5_resp_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o |-> cpu_req_i);

  a_r3_forward_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rvalid_o && !buf_ok) |-> (mem_rvalid_i && cpu_rdata_o == mem_rdata_i));
endmodule

bind cwf_refill cwf_refill_chk #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
  .clk_i, .rst_ni, .cpu_req_i, .cpu_rvalid_o, .cpu_rdata_o, .mem_req_o, .mem_gnt_i,
  .mem_line_o, .mem_off_o, .mem_rvalid_i, .mem_rdata_i, .line_full_o, .buf_ok
);

// File: tb/cwf_refill_bench.sv
module cwf_refill_bench;
  localparam int N = 4, DW = 32, LW = 8, OW = 2, NREQ = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cpu_req_i = 1'b0, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [LW-1:0] cpu_line_i = '0;
  logic [OW-1:0] cpu_off_i = '0, mem_roff_i = '0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic cpu_rvalid_o, mem_req_o, line_full_o;
  logic [DW-1:0] cpu_rdata_o;
  logic [LW-1:0] mem_line_o;
  logic [OW-1:0] mem_off_o;

  always #2 clk_i = ~clk_i;

  cwf_refill #(.WORDS(N), .DATA_W(DW), .LINE_W(LW)) u_cwf_refill (.*);

  int checks = 0, fails = 0, cyc = 0;
  int m_busy = 0, m_held = 0, m_line = 0, m_crit = 0, m_cnt = 0;
  int m_valid[N];
  int m_data[N];
  int q_line[$], q_off[$], q_due[$];

  function automatic int word_of(int ln, int off);
    return 32'hA000_0000 + ln * 256 + off;
  endfunction

  function automatic int scr_line(int i);
    case (i)
      0: return 5; 1: return 7; 2: return 7; 3: return 7; 4: return 5;
      5: return 3; 6: return 3; 7: return 3; 8: return 3; default: return 9;
    endcase
  endfunction

  function automatic int scr_off(int i);
    case (i)
      0: return 2; 1: return 0; 2: return 3; 3: return 0; 4: return 1;
      5: return 3; 6: return 0; 7: return 3; 8: return 2; default: return 1;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  initial begin
    int idx = 0;
    int ok_all;
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 mem_req", int'(mem_req_o), 0);
    chk("R8 rvalid", int'(cpu_rvalid_o), 0);
    chk("R8 line_full", int'(line_full_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    while (1) begin
      int same, ok, fwd, e_rv, e_rd, e_mreq, e_full;
      if (cyc > 5000) begin
        fails++; checks++;
        $display("FAIL watchdog expired cyc=%0d actual=1 expected=0", cyc);
        break;
      end
      if (idx >= NREQ && m_busy == 0 && q_off.size() == 0) break;
      // drive inputs
      mem_gnt_i = (cyc % 3) != 1;
      mem_rvalid_i = 1'b0;
      if (q_due.size() > 0 && q_due[0] <= cyc) begin
        mem_rvalid_i = 1'b1;
        mem_roff_i = OW'(q_off[0]);
        mem_rdata_i = DW'(word_of(q_line[0], q_off[0]));
        void'(q_line.pop_front()); void'(q_off.pop_front()); void'(q_due.pop_front());
      end
      cpu_req_i = idx < NREQ;
      cpu_line_i = LW'(scr_line(idx));
      cpu_off_i = OW'(scr_off(idx));
      #1;
      // expectations from model state
      same = (m_held != 0 && int'(cpu_line_i) == m_line);
      ok = m_valid[int'(cpu_off_i)];
      fwd = (mem_rvalid_i && m_busy != 0 && mem_roff_i == cpu_off_i);
      e_rv = (cpu_req_i && same && (ok != 0 || fwd != 0));
      e_rd = (ok != 0) ? m_data[int'(cpu_off_i)] : int'(mem_rdata_i);
      e_mreq = (m_busy != 0 && m_cnt < N);
      ok_all = 1;
      for (int i = 0; i < N; i++) if (m_valid[i] == 0) ok_all = 0;
      e_full = (m_held != 0 && ok_all != 0);
      if (cpu_req_i && !same) chk("R7 rvalid other line", int'(cpu_rvalid_o), 0);
      else if (cpu_req_i && ok == 0 && fwd == 0) chk("R5 stall", int'(cpu_rvalid_o), 0);
      else chk("R4 rvalid", int'(cpu_rvalid_o), e_rv);
      if (e_rv) chk(ok != 0 ? "R4 buffer data" : "R3 forward data", int'(cpu_rdata_o), e_rd);
      chk("R9 mem_req", int'(mem_req_o), e_mreq);
      if (e_mreq) begin
        chk(m_cnt == 0 ? "R1 first offset" : "R2 wrap offset", int'(mem_off_o), (m_crit + m_cnt) % N);
        chk("R1 mem_line", int'(mem_line_o), m_line);
      end
      chk("R6 line_full", int'(line_full_o), e_full);
      // model update (posedge)
      if (e_mreq && mem_gnt_i) begin
        q_line.push_back(m_line); q_off.push_back((m_crit + m_cnt) % N); q_due.push_back(cyc + 2);
        m_cnt++;
      end
      if (mem_rvalid_i && m_busy != 0) begin
        m_valid[int'(mem_roff_i)] = 1;
        m_data[int'(mem_roff_i)] = int'(mem_rdata_i);
        ok_all = 1;
        for (int i = 0; i < N; i++) if (m_valid[i] == 0) ok_all = 0;
        if (ok_all != 0) m_busy = 0;
      end
      if (cpu_req_i && !same && m_busy == 0 && !(mem_rvalid_i && ok_all != 0 && same == 0 && 0)) begin
        if (!(mem_rvalid_i)) begin end
      end
      if (cpu_req_i && !same && e_mreq == 0 && !(mem_rvalid_i) && m_busy == 0) begin
        m_busy = 1; m_held = 1; m_line = int'(cpu_line_i); m_crit = int'(cpu_off_i); m_cnt = 0;
        for (int i = 0; i < N; i++) m_valid[i] = 0;
      end
      if (e_rv) idx++;
      @(negedge clk_i);
      cyc++;
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule